// File: doc/BRIEF.md
# Single-Channel DMA Packet Endpoint with Read Throttling

This block is the user-side end of one DMA channel. It sits behind a 256-entry, 64-bit memory. Packets arrive on an inbound beat stream. Each beat carries a control byte that says what kind of beat it is: a starting dword address, a transfer length, or payload. Write payload is stored with per-dword enables. The endpoint holds the inbound stream with an advance output whenever it cannot take a beat.

A read request causes the endpoint to return exactly the requested number of dwords on an outbound beat stream. The returned beats are aligned to the memory's 64-bit words. The unused half of the first and last beat is masked, and the final beat is flagged. A downstream almost-full input pauses the return stream. The stream resumes where it stopped once the flag clears. The sender must never request a length of zero.

Top module: `dmae_endpoint`

## Requirements
- R1: During and straight after reset, `out_valid` is 0 and `in_advance` is 1.
- R2: An inbound beat's kind is set by `in_ctrl[1:0]`: 01 means address (a dword address, stored in memory word address[8:1]), 10 means length (dwords, in `in_data[23:0]`), and 00 means data. The value 11 never occurs. `in_ctrl[4]` on the address beat selects a read (1) or a write (0).
- R3: Data beat k of a write (k from 0) goes to memory word (address[8:1] + k) mod 256. `in_ctrl[3]` enables the upper dword (bits 63:32) and `in_ctrl[2]` enables the lower dword. A disabled half keeps its old contents.
- R4: A beat is taken only in a cycle where `in_valid` and `in_advance` are both 1. A write stays open across gaps in `in_valid` until the next address beat arrives.
- R5: A data beat that arrives when no write is open (for example after a read) changes no memory contents.
- R6: A read of L dwords at address A returns ceil((A[0]+L)/2) beats. Beat k holds word A[8:1]+k. `out_ctrl[0]` enables the lower dword and `out_ctrl[1]` the upper. The first beat's lower dword is off when A is odd, and the last beat's upper dword is off when A+L-1 is even. Disabled halves read as zero, and `out_ctrl[2]` and `out_ctrl[7:4]` are zero.
- R7: `out_ctrl[3]` is 1 on the final beat of a read and 0 on every other beat.
- R8: `out_valid` is 0 in every cycle that follows a cycle with `out_almost_full` at 1. The return then continues with no beat lost or repeated.
- R9: `in_advance` is 0 from the cycle after a read's length beat until the cycle the final return beat appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | 64 | Inbound address, length or payload |
| in_ctrl | input | 8 | Inbound beat kind, read flag, dword enables |
| in_valid | input | 1 | Inbound beat present |
| in_advance | output | 1 | Endpoint can take an inbound beat |
| out_data | output | 64 | Read return payload |
| out_ctrl | output | 8 | Return dword enables and last flag |
| out_valid | output | 1 | Return beat present |
| out_almost_full | input | 1 | Downstream asks the return stream to pause |

## Verification
Some rules are checked by the assertions on every cycle. These are the one-cycle stop on almost-full, the shape of the return control byte, idleness after a final beat, inbound blocking once a read starts, and the absence of the reserved beat kind. Other behaviour can only be shown by the bench's scenarios. This covers where write dwords land, masking of partial dwords, wrap at the top of the memory, writes that span a valid gap, stray data beats being ignored, and exact beat counts for every start parity and short length. The bench shows these by reading back through the return stream against a dword-level model, under several almost-full patterns.

// File: rtl/dmae_pkg.sv
// Shared encodings for the DMA endpoint.
// Assumes the control-byte bit positions are fixed by the link partner.
package dmae_pkg;
    typedef enum logic [1:0] {
        BEAT_DATA = 2'b00,
        BEAT_ADDR = 2'b01,
        BEAT_LEN  = 2'b10,
        BEAT_RSVD = 2'b11
    } beat_kind_t;

    localparam int READ_FLAG_BIT = 4;
    localparam int IN_EN_HI_BIT  = 3;
    localparam int IN_EN_LO_BIT  = 2;
    localparam int OUT_LAST_BIT  = 3;
endpackage

// File: rtl/dmae_rx_decode.sv
// Inbound beat decoder: tracks packet state, produces memory writes and
// launches reads. Assumes the read engine reports busy until its final beat.
module dmae_rx_decode
    import dmae_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int LEN_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [63:0]      in_data,
    input  logic [7:0]       in_ctrl,
    input  logic             in_valid,
    input  logic             rd_busy,
    output logic             in_advance,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [63:0]      wr_data,
    output logic [1:0]       wr_dwen,
    output logic             rd_start,
    output logic [IDX_W:0]   rd_addr,
    output logic [LEN_W-1:0] rd_len
);
    logic             take;
    beat_kind_t       kind;
    logic [IDX_W:0]   pkt_addr;
    logic             pkt_read;
    logic             wr_open;
    logic [IDX_W-1:0] wr_ptr;

    // Beat acceptance and kind extraction
    always_comb begin
        in_advance = !rd_busy;
        take       = in_valid && in_advance;
        kind       = beat_kind_t'(in_ctrl[1:0]);
    end

    // Packet state: address latch, direction, open write and its pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_addr <= '0;
            pkt_read <= 1'b0;
            wr_open  <= 1'b0;
            wr_ptr   <= '0;
        end else if (take) begin
            case (kind)
                BEAT_ADDR: begin
                    pkt_addr <= in_data[IDX_W:0];
                    pkt_read <= in_ctrl[READ_FLAG_BIT];
                    wr_open  <= 1'b0;
                    wr_ptr   <= in_data[IDX_W:1];
                end
                BEAT_LEN:  wr_open <= !pkt_read;
                BEAT_DATA: if (wr_open) wr_ptr <= wr_ptr + IDX_W'(1);
                default:   ;
            endcase
        end
    end

    // Memory write strobe and read launch
    always_comb begin
        wr_en    = take && (kind == BEAT_DATA) && wr_open;
        wr_idx   = wr_ptr;
        wr_data  = in_data;
        wr_dwen  = {in_ctrl[IN_EN_HI_BIT], in_ctrl[IN_EN_LO_BIT]};
        rd_start = take && (kind == BEAT_LEN) && pkt_read;
        rd_addr  = pkt_addr;
        rd_len   = in_data[LEN_W-1:0];
    end

    // R2: the reserved beat kind never appears on a valid beat
    p_no_rsvd_kind_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (in_ctrl[1:0] != 2'b11));

    // R9: once a read is launched the inbound stream is held
    p_hold_inbound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> !in_advance);
endmodule

// File: rtl/dmae_store.sv
// Word memory split into two dword halves, each with its own write enable.
// Asynchronous read; contents are not reset.
module dmae_store #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [63:0]      wr_data,
    input  logic [1:0]       wr_dwen,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [63:0]      rd_data
);
    localparam int DEPTH = 1 << IDX_W;

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [31:0] cells [DEPTH];

        // Store this half when its dword enable is set
        always_ff @(posedge clk) begin
            if (wr_en && wr_dwen[h]) cells[wr_idx] <= wr_data[h*32 +: 32];
        end

        // Present this half of the addressed word
        always_comb rd_data[h*32 +: 32] = cells[rd_idx];
    end
endmodule

// File: rtl/dmae_tx_engine.sv
// Read return engine: walks memory words, masks partial dwords, flags the
// last beat and pauses on almost-full. Assumes a nonzero length and no new
// start while busy.
module dmae_tx_engine
    import dmae_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int LEN_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W:0]   st_addr,
    input  logic [LEN_W-1:0] st_len,
    input  logic             almost_full,
    input  logic [63:0]      rd_data,
    output logic [IDX_W-1:0] rd_idx,
    output logic             busy,
    output logic [63:0]      out_data,
    output logic [7:0]       out_ctrl,
    output logic             out_valid
);
    logic [IDX_W-1:0] ptr;
    logic [LEN_W:0]   left;
    logic [LEN_W:0]   beat_sum;
    logic             first;
    logic             skip_lo;
    logic             drop_hi;
    logic             issue;
    logic             last;
    logic             lo_en;
    logic             hi_en;

    // Beat count, issue decision and dword masks for the current beat
    always_comb begin
        beat_sum = {1'b0, st_len} + (LEN_W+1)'(st_addr[0]) + (LEN_W+1)'(1);
        issue    = busy && !almost_full;
        last     = (left == (LEN_W+1)'(1));
        lo_en    = !(first && skip_lo);
        hi_en    = !(last && drop_hi);
        rd_idx   = ptr;
    end

    // Walk state and registered return beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            ptr       <= '0;
            left      <= '0;
            first     <= 1'b0;
            skip_lo   <= 1'b0;
            drop_hi   <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_ctrl  <= '0;
        end else begin
            out_valid <= issue;
            if (start) begin
                busy    <= 1'b1;
                ptr     <= st_addr[IDX_W:1];
                left    <= beat_sum >> 1;
                first   <= 1'b1;
                skip_lo <= st_addr[0];
                drop_hi <= st_addr[0] ^ st_len[0];
            end else if (issue) begin
                out_data <= {hi_en ? rd_data[63:32] : 32'h0,
                             lo_en ? rd_data[31:0]  : 32'h0};
                out_ctrl <= {4'b0, last, 1'b0, hi_en, lo_en};
                ptr      <= ptr + IDX_W'(1);
                left     <= left - (LEN_W+1)'(1);
                first    <= 1'b0;
                if (last) busy <= 1'b0;
            end
        end
    end

    // R8: no return beat in the cycle after almost-full was seen
    p_stop_on_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(almost_full) |-> !out_valid);

    // R6: every return beat carries at least one dword and clean reserved bits
    p_ctrl_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_ctrl[7:4] == 4'h0 && !out_ctrl[2] && out_ctrl[1:0] != 2'b00));

    // R7: a final beat is never directly followed by another beat
    p_last_then_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ctrl[OUT_LAST_BIT]) |=> !out_valid);
endmodule

// File: rtl/dmae_endpoint.sv
// Top of the single-channel DMA endpoint: inbound decoder, word memory and
// read return engine. Assumes the sender never issues a zero-length read.
module dmae_endpoint #(
    parameter int IDX_W = 8,
    parameter int LEN_W = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [63:0] in_data,
    input  logic [7:0]  in_ctrl,
    input  logic        in_valid,
    output logic        in_advance,
    output logic [63:0] out_data,
    output logic [7:0]  out_ctrl,
    output logic        out_valid,
    input  logic        out_almost_full
);
    logic             rd_busy;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [63:0]      wr_data;
    logic [1:0]       wr_dwen;
    logic             rd_start;
    logic [IDX_W:0]   rd_addr;
    logic [LEN_W-1:0] rd_len;
    logic [IDX_W-1:0] mem_idx;
    logic [63:0]      mem_data;

    dmae_rx_decode #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_ctrl(in_ctrl),
        .in_valid(in_valid), .rd_busy(rd_busy), .in_advance(in_advance),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_dwen(wr_dwen),
        .rd_start(rd_start), .rd_addr(rd_addr), .rd_len(rd_len)
    );

    dmae_store #(.IDX_W(IDX_W)) u_store (
        .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .wr_dwen(wr_dwen), .rd_idx(mem_idx), .rd_data(mem_data)
    );

    dmae_tx_engine #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .start(rd_start), .st_addr(rd_addr),
        .st_len(rd_len), .almost_full(out_almost_full), .rd_data(mem_data),
        .rd_idx(mem_idx), .busy(rd_busy), .out_data(out_data),
        .out_ctrl(out_ctrl), .out_valid(out_valid)
    );

    // R1: the endpoint is ready for inbound beats right after reset
    p_ready_after_reset_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (in_advance && !out_valid));
endmodule

// File: tb/dmae_endpoint_tb.sv
`timescale 1ns/1ps
module dmae_endpoint_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] in_data = '0;
    logic [7:0]  in_ctrl = '0;
    logic        in_valid = 1'b0;
    logic        in_advance;
    logic [63:0] out_data;
    logic [7:0]  out_ctrl;
    logic        out_valid;
    logic        out_almost_full = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [31:0] sh [512];

    always #2.5 clk = ~clk;

    dmae_endpoint u_dut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_ctrl(in_ctrl),
        .in_valid(in_valid), .in_advance(in_advance), .out_data(out_data),
        .out_ctrl(out_ctrl), .out_valid(out_valid),
        .out_almost_full(out_almost_full)
    );

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(int d, int seed);
        return {seed[15:0], d[15:0]};
    endfunction

    function automatic bit af_of(int m, int c);
        case (m)
            1:       return c[0];
            2:       return (c % 3) == 2;
            3:       return (c % 7) < 3;
            default: return 1'b0;
        endcase
    endfunction

    // Present one beat and wait until it is taken
    task automatic send_beat(logic [63:0] d, logic [7:0] c);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_ctrl = c;
        while (!in_advance) @(negedge clk);
        @(posedge clk); #1;
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0; in_ctrl = 8'h00;
        end
    endtask

    // Write l dwords at dword address a; disabled halves carry junk
    task automatic do_write(int a, int l, int seed, int gap_at);
        int nb = ((a & 1) + l + 1) / 2;
        int base = a & ~1;
        send_beat(64'(a), 8'h01);
        send_beat(64'(l), 8'h02);
        for (int k = 0; k < nb; k++) begin
            int dlo = base + 2 * k;
            int dhi = dlo + 1;
            bit elo = (dlo >= a) && (dlo <= a + l - 1);
            bit ehi = (dhi >= a) && (dhi <= a + l - 1);
            if (k == gap_at) idle(3);
            send_beat({ehi ? pat(dhi, seed) : 32'hBAD0_BAD0,
                       elo ? pat(dlo, seed) : 32'hBAD1_BAD1},
                      {4'b0, ehi, elo, 2'b00});
            if (ehi) sh[dhi & 511] = pat(dhi, seed);
            if (elo) sh[dlo & 511] = pat(dlo, seed);
        end
        idle(1);
    endtask

    // Read l dwords at a under almost-full pattern m; tag names data checks
    task automatic do_read(int a, int l, int m, string tag);
        int nb = ((a & 1) + l + 1) / 2;
        int base = a & ~1;
        int got = 0;
        int cyc = 0;
        bit af_prev = 1'b0;
        bit afbad = 1'b0;
        bit advbad = 1'b0;
        bit extra = 1'b0;
        send_beat(64'(a), 8'h11);
        send_beat(64'(l), 8'h02);
        while (got < nb && cyc < 600) begin
            @(negedge clk);
            in_valid = 1'b0; in_ctrl = 8'h00;
            if (out_valid) begin
                int dlo = base + 2 * got;
                int dhi = dlo + 1;
                bit elo = (dlo >= a) && (dlo <= a + l - 1);
                bit ehi = (dhi >= a) && (dhi <= a + l - 1);
                bit lst = (got == nb - 1);
                logic [63:0] exp_d = {ehi ? sh[dhi & 511] : 32'h0,
                                      elo ? sh[dlo & 511] : 32'h0};
                if (af_prev) afbad = 1'b1;
                chk(out_data == exp_d, tag, "return data", out_data, exp_d);
                chk({out_ctrl[7:4], out_ctrl[2:0]} == {4'b0, 1'b0, ehi, elo},
                    "R6", "return enables", 64'(out_ctrl), 64'({4'b0, lst, 1'b0, ehi, elo}));
                chk(out_ctrl[3] == lst, "R7", "last flag", 64'(out_ctrl[3]), 64'(lst));
                if (!lst && in_advance) advbad = 1'b1;
                if (lst) chk(in_advance == 1'b1, "R9", "advance after final", 64'(in_advance), 64'd1);
                got++;
            end else if (in_advance) begin
                advbad = 1'b1;
            end
            out_almost_full = af_of(m, cyc);
            af_prev = out_almost_full;
            cyc++;
        end
        out_almost_full = 1'b0;
        chk(got == nb, "R6", "beat count", 64'(got), 64'(nb));
        chk(!afbad, "R8", "beat after almost-full", 64'(afbad), 64'd0);
        chk(!advbad, "R9", "advance during read", 64'(advbad), 64'd0);
        repeat (3) begin
            @(negedge clk);
            if (out_valid) extra = 1'b1;
        end
        chk(!extra, "R6", "extra beat", 64'(extra), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "valid in reset", 64'(out_valid), 64'd0);
        chk(in_advance == 1'b1, "R1", "advance in reset", 64'(in_advance), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0 && in_advance == 1'b1, "R1", "after reset",
            64'({out_valid, in_advance}), 64'b01);

        // R2 R3: fill the whole memory, read it all back
        do_write(0, 512, 1, 40);
        do_read(0, 512, 1, "R2");

        // R3 R4 R6 R8: every start parity and short length, with neighbours
        for (int a = 0; a < 6; a++) begin
            for (int l = 1; l < 8; l++) begin
                do_write(a + 40, l, 100 + a * 8 + l, (l > 4) ? 1 : -1);
                do_read(a + 40, l, (a + l) % 4, (l > 4) ? "R4" : "R3");
                do_read(a + 39, l + 2, (a + l + 1) % 4, "R3");
            end
        end

        // R3: wrap past the top word
        do_write(509, 6, 7, 2);
        do_read(508, 8, 1, "R3");

        // R5: stray data beat after a read must not land anywhere
        do_read(100, 3, 0, "R3");
        send_beat(64'hFFFF_FFFF_FFFF_FFFF, 8'h0C);
        idle(1);
        do_read(100, 4, 2, "R5");

        // R8: long hold of almost-full mid-read
        do_read(200, 9, 3, "R8");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule